// File: doc/BRIEF.md
# Host-Bus Ready-Driven Stall Unit

This block paces accesses on an external host bus by following a ready pin from the target device. Each bus clock it samples the pin and turns it into a "busy" bit, using a programmable polarity. It then passes that bit through a short shift pipeline whose tap is chosen by a delay code. When monitoring is enabled, the tapped bit is the stall signal. The stall freezes a small access sequencer, so a device can stretch the gap between the address phase and the data phase. The delay code lets the stall be timed ahead of the data phase.

On the internal side a requester raises a request with an address and a wait-state count. It holds the request until a one-cycle acknowledge returns. On the external side the sequencer drives a chip select, an address-latch strobe, a data-phase strobe and the latched address. The ready pin passes through a two-flop synchronizer, which is also the first part of the programmable delay. An asynchronous active-low reset, released synchronously inside the block, returns the pipeline to not-stalled and the sequencer to idle.

Top module: `hb_stall_unit`

## Requirements
- R1: During reset and in the first cycles after reset release: `bus_cs_n_o`=1, `bus_ale_o`=0, `bus_dstb_o`=0, `ack_o`=0, `stall_o`=0, and `bus_addr_o`=0.
- R2: While `cfg_rdy_en`=0, `stall_o` is 0 whatever `bus_rdy_i` does. Every access then completes with no extra cycles.
- R3: With `cfg_rdy_inv`=0, a sampled low on `bus_rdy_i` means not ready. With `cfg_rdy_inv`=1, a sampled high means not ready.
- R4: A pin level sampled at clock edge k sets `stall_o` from just after edge k+N, where N is the delay code. The codes are 2'b01=1, 2'b10=2 and 2'b11=3. Code 2'b00 behaves as 1.
- R5: A request accepted in idle gives one address cycle (`bus_ale_o`=1, `bus_cs_n_o`=0). Then come `cfg_wait` wait cycles and one data cycle (`bus_dstb_o`=1, `bus_cs_n_o`=0). Then `ack_o` is high for one cycle with `bus_cs_n_o`=1, and the sequencer returns to idle.
- R6: The address cycle always lasts exactly one clock, even when `stall_o` is high.
- R7: When `stall_o` is high during a wait or data cycle, the sequencer holds its state and all bus outputs at the next edge. It advances on the first edge at which `stall_o` is low.
- R8: Every accepted request produces exactly one acknowledge. `bus_addr_o` shows the address captured on acceptance from the address cycle until the next request is accepted.
- R9: A wait count of 0 goes from the address cycle straight to the data cycle. The count is captured when the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rdy_en | input | 1 | Enables stalling on the ready pin |
| cfg_rdy_inv | input | 1 | Inverts the ready pin's sense |
| cfg_rdy_dly | input | 2 | Delay code, from sampling to stall |
| cfg_wait | input | WAIT_W (4) | Wait-state count, captured on request |
| req_i | input | 1 | Access request, held until acknowledged |
| req_addr_i | input | ADDR_W (16) | Access address |
| ack_o | output | 1 | One-cycle access completion |
| bus_cs_n_o | output | 1 | Active-low chip select |
| bus_ale_o | output | 1 | Address-latch strobe |
| bus_dstb_o | output | 1 | Data-phase strobe |
| bus_addr_o | output | ADDR_W (16) | Latched access address |
| bus_rdy_i | input | 1 | External ready pin |
| stall_o | output | 1 | Delayed, enabled stall in effect |

## Verification
A wrong stage in the ready pipeline shows on `stall_o` after the programmed delay, 1 to 3 cycles after the offending pin sample. A sequencer that ignores or over-applies the stall shows on the same or the next clock as a strobe that moves or holds when it should not. A wrong wait counter or captured address shows as a misplaced data strobe or a wrong `bus_addr_o` within the same access. A dropped or doubled access shows as a missing or extra `ack_o` against the count of requests.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE = 3'd0,
    SEQ_ADDR = 3'd1,
    SEQ_WAIT = 3'd2,
    SEQ_DATA = 3'd3,
    SEQ_DONE = 3'd4
  } seq_state_e;

  // Delay code to pipeline tap; a zero code behaves as one stage.
  function automatic int unsigned tap_of_code(input int unsigned code);
    return (code == 0) ? 1 : code;
  endfunction

endpackage

// File: rtl/hbs_rst_sync.sv
module hbs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/hbs_ready_pipe.sv
module hbs_ready_pipe import hbs_pkg::*; #(
  parameter int MAX_DLY = 3,
  parameter int CODE_W  = 2
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              rdy_pin_i,
  input  logic              inv_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              stall_o
);

  localparam int NSTG = MAX_DLY + 1;

  logic            busy_in;
  logic [NSTG-1:0] stg_q;
  logic [NSTG-1:0] stg_d;
  logic            tap;

  // A pin level that means "not ready" after polarity selection.
  always_comb busy_in = ~(rdy_pin_i ^ inv_i);

  // Stage 0 and 1 form the synchronizer, the rest are extra delay.
  always_comb begin
    stg_d[0] = busy_in;
    for (int i = 1; i < NSTG; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  always_comb begin
    tap = stg_q[1];
    for (int i = 1; i < NSTG; i++) begin
      if (tap_of_code(int'(code_i)) == i) tap = stg_q[i];
    end
  end

  always_comb stall_o = en_i & tap;

endmodule

// File: rtl/hbs_access_seq.sv
module hbs_access_seq import hbs_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              ack_o,
  output logic              cs_n_o,
  output logic              ale_o,
  output logic              dstb_o,
  output logic [ADDR_W-1:0] addr_o
);

  seq_state_e        st_q, st_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              hold_phase;
  logic              adv_en;

  always_comb begin
    hold_phase = (st_q == SEQ_WAIT) || (st_q == SEQ_DATA);
    adv_en     = !(stall_i && hold_phase);
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    unique case (st_q)
      SEQ_IDLE: begin
        if (req_i) begin
          st_d   = SEQ_ADDR;
          cnt_d  = wait_i;
          addr_d = req_addr_i;
        end
      end
      SEQ_ADDR: st_d = (cnt_q == '0) ? SEQ_DATA : SEQ_WAIT;
      SEQ_WAIT: begin
        if (cnt_q <= WAIT_W'(1)) st_d = SEQ_DATA;
        else                     cnt_d = cnt_q - WAIT_W'(1);
      end
      SEQ_DATA: st_d = SEQ_DONE;
      SEQ_DONE: st_d = SEQ_IDLE;
      default:  st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SEQ_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (adv_en) begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
    end
  end

  always_comb begin
    cs_n_o = !((st_q == SEQ_ADDR) || hold_phase);
    ale_o  = (st_q == SEQ_ADDR);
    dstb_o = (st_q == SEQ_DATA);
    ack_o  = (st_q == SEQ_DONE);
    addr_o = addr_q;
  end

  AST_ADDR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == SEQ_ADDR) |=> (st_q != SEQ_ADDR)); // R6

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_ni)
    (stall_i && hold_phase) |=> $stable(st_q) && $stable(cnt_q)); // R7

  AST_DATA_BEFORE_ACK: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(st_q == SEQ_DATA)); // R5

  AST_SINGLE_ACK: assert property (@(posedge clk) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R8

  AST_WAIT_HAS_COUNT: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == SEQ_WAIT) |-> (cnt_q != '0)); // R9

endmodule

// File: rtl/hb_stall_unit.sv
module hb_stall_unit import hbs_pkg::*; #(
  parameter int ADDR_W  = 16,
  parameter int WAIT_W  = 4,
  parameter int MAX_DLY = 3,
  parameter int CODE_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rdy_en,
  input  logic              cfg_rdy_inv,
  input  logic [CODE_W-1:0] cfg_rdy_dly,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              ack_o,
  output logic              bus_cs_n_o,
  output logic              bus_ale_o,
  output logic              bus_dstb_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              bus_rdy_i,
  output logic              stall_o
);

  logic rst_i_n;
  logic stall_w;

  hbs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  hbs_ready_pipe #(
    .MAX_DLY (MAX_DLY),
    .CODE_W  (CODE_W)
  ) u_pipe (
    .clk       (clk),
    .rst_ni    (rst_i_n),
    .rdy_pin_i (bus_rdy_i),
    .inv_i     (cfg_rdy_inv),
    .en_i      (cfg_rdy_en),
    .code_i    (cfg_rdy_dly),
    .stall_o   (stall_w)
  );

  hbs_access_seq #(
    .ADDR_W (ADDR_W),
    .WAIT_W (WAIT_W)
  ) u_seq (
    .clk        (clk),
    .rst_ni     (rst_i_n),
    .stall_i    (stall_w),
    .req_i      (req_i),
    .req_addr_i (req_addr_i),
    .wait_i     (cfg_wait),
    .ack_o      (ack_o),
    .cs_n_o     (bus_cs_n_o),
    .ale_o      (bus_ale_o),
    .dstb_o     (bus_dstb_o),
    .addr_o     (bus_addr_o)
  );

  assign stall_o = stall_w;

  AST_FREEZE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (stall_w && bus_dstb_o) |=> bus_dstb_o); // R7

  AST_ALE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(bus_ale_o) |-> $past(bus_cs_n_o)); // R5

endmodule

// File: tb/hb_stall_unit_tb.sv
module hb_stall_unit_tb;
  localparam int ADDR_W = 16;
  localparam int WAIT_W = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n, cfg_rdy_en, cfg_rdy_inv, req_i, bus_rdy_i;
  logic [1:0]        cfg_rdy_dly;
  logic [WAIT_W-1:0] cfg_wait;
  logic [ADDR_W-1:0] req_addr_i, bus_addr_o;
  logic              ack_o, bus_cs_n_o, bus_ale_o, bus_dstb_o, stall_o;

  hb_stall_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_rdy_en(cfg_rdy_en), .cfg_rdy_inv(cfg_rdy_inv),
    .cfg_rdy_dly(cfg_rdy_dly), .cfg_wait(cfg_wait), .req_i(req_i),
    .req_addr_i(req_addr_i), .ack_o(ack_o), .bus_cs_n_o(bus_cs_n_o),
    .bus_ale_o(bus_ale_o), .bus_dstb_o(bus_dstb_o), .bus_addr_o(bus_addr_o),
    .bus_rdy_i(bus_rdy_i), .stall_o(stall_o)
  );

  int    n_cmp = 0, n_bad = 0, n_req = 0, n_ack = 0, cyc = 0;
  string tag = "R1";

  // Reference model: 0 idle, 1 address, 2 wait, 3 data, 4 done
  int              m_st, m_cnt;
  logic [ADDR_W-1:0] m_addr;
  logic            mb[4];
  logic            mr1, mr2;

  function automatic logic m_stall();
    int idx;
    idx = (cfg_rdy_dly == 2'd0) ? 1 : int'(cfg_rdy_dly);
    return cfg_rdy_en && mb[idx];
  endfunction

  task automatic m_reset();
    m_st = 0; m_cnt = 0; m_addr = '0;
    for (int i = 0; i < 4; i++) mb[i] = 1'b0;
  endtask

  always @(posedge clk) begin
    logic old_r2, stl;
    if (!rst_n) begin
      mr1 = 1'b0; mr2 = 1'b0; m_reset();
    end else begin
      old_r2 = mr2; mr2 = mr1; mr1 = 1'b1;
      if (!old_r2) m_reset();
      else begin
        stl = m_stall();
        case (m_st)
          0: if (req_i) begin m_st = 1; m_cnt = int'(cfg_wait); m_addr = req_addr_i; end
          1: m_st = (m_cnt == 0) ? 3 : 2;
          2: if (!stl) begin if (m_cnt <= 1) m_st = 3; else m_cnt = m_cnt - 1; end
          3: if (!stl) m_st = 4;
          default: m_st = 0;
        endcase
        mb[3] = mb[2]; mb[2] = mb[1]; mb[1] = mb[0];
        mb[0] = cfg_rdy_inv ? bus_rdy_i : !bus_rdy_i;
      end
    end
  end

  task automatic chk(string r, string nm, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", r, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(tag, "cs_n",  32'(bus_cs_n_o), 32'(!(m_st >= 1 && m_st <= 3)));
      chk(tag, "ale",   32'(bus_ale_o),  32'(m_st == 1));
      chk(tag, "dstb",  32'(bus_dstb_o), 32'(m_st == 3));
      chk(tag, "ack",   32'(ack_o),      32'(m_st == 4));
      chk(tag, "addr",  32'(bus_addr_o), 32'(m_addr));
      chk(tag, "stall", 32'(stall_o),    32'(m_stall()));
      if (ack_o) n_ack++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk); #2;
      if (ack_o) req_i = 1'b0;
    end
  endtask

  task automatic start_req(logic [ADDR_W-1:0] a, int w);
    req_i = 1'b1; req_addr_i = a; cfg_wait = WAIT_W'(w); n_req++;
  endtask

  task automatic wait_ack();
    for (int i = 0; i < 400 && req_i; i++) step(1);
    step(1);
  endtask

  initial begin
    rst_n = 1'b0; cfg_rdy_en = 1'b0; cfg_rdy_inv = 1'b0; cfg_rdy_dly = 2'd1;
    cfg_wait = '0; req_i = 1'b0; req_addr_i = '0; bus_rdy_i = 1'b1;
    step(4);
    rst_n = 1'b1;
    tag = "R1";
    #1;
    chk("R1", "cs_n reset", 32'(bus_cs_n_o), 32'd1);
    chk("R1", "stall reset", 32'(stall_o), 32'd0);
    step(4);

    tag = "R5"; start_req(16'h1234, 2); wait_ack();
    start_req(16'hA5A5, 5); wait_ack();
    tag = "R9"; start_req(16'h0F0F, 0); wait_ack();

    tag = "R2"; bus_rdy_i = 1'b0; start_req(16'h2222, 3); wait_ack();
    step(3);
    chk("R2", "stall while disabled", 32'(stall_o), 32'd0);

    tag = "R3"; cfg_rdy_en = 1'b1; bus_rdy_i = 1'b1; step(4);
    bus_rdy_i = 1'b0; step(1); bus_rdy_i = 1'b1; step(5);
    cfg_rdy_inv = 1'b1; bus_rdy_i = 1'b0; step(5);
    bus_rdy_i = 1'b1; step(1); bus_rdy_i = 1'b0; step(5);
    cfg_rdy_inv = 1'b0; bus_rdy_i = 1'b1; step(4);

    tag = "R4";
    for (int c = 0; c < 4; c++) begin
      cfg_rdy_dly = 2'(c); step(4);
      bus_rdy_i = 1'b0; step(1); bus_rdy_i = 1'b1; step(5);
    end

    tag = "R7";
    for (int d = 1; d < 4; d++) begin
      cfg_rdy_dly = 2'(d);
      start_req(16'h7000 + 16'(d), 3); step(2);
      bus_rdy_i = 1'b0; step(3); bus_rdy_i = 1'b1; wait_ack();
      start_req(16'h7100 + 16'(d), 0); step(1);
      bus_rdy_i = 1'b0; step(4); bus_rdy_i = 1'b1; wait_ack();
    end

    tag = "R6"; cfg_rdy_dly = 2'd1; bus_rdy_i = 1'b0; step(4);
    start_req(16'h6666, 2); step(6);
    bus_rdy_i = 1'b1; wait_ack();
    bus_rdy_i = 1'b0; step(4); start_req(16'h6667, 0); step(6);
    bus_rdy_i = 1'b1; wait_ack();

    tag = "R8";
    for (int i = 0; i < 800; i++) begin
      bus_rdy_i = (($urandom % 4) != 0) ? ~cfg_rdy_inv : cfg_rdy_inv;
      if (($urandom % 40) == 0) cfg_rdy_dly = 2'($urandom);
      if (($urandom % 90) == 0) cfg_rdy_en = ~cfg_rdy_en;
      if (($urandom % 150) == 0) cfg_rdy_inv = ~cfg_rdy_inv;
      if (!req_i && (($urandom % 3) == 0)) start_req(16'($urandom), int'($urandom % 6));
      step(1);
    end
    bus_rdy_i = ~cfg_rdy_inv; wait_ack(); step(3);
    chk("R8", "ack count", 32'(n_ack), 32'(n_req));

    tag = "R1"; cfg_rdy_en = 1'b1; cfg_rdy_inv = 1'b0; cfg_rdy_dly = 2'd3;
    bus_rdy_i = 1'b0; step(3);
    rst_n = 1'b0; step(2);
    rst_n = 1'b1; bus_rdy_i = 1'b1; #1;
    chk("R1", "stall after reset", 32'(stall_o), 32'd0);
    step(6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule